// File: doc/BRIEF.md
# External Interrupt Trigger Configuration Unit

This block conditions up to six external interrupt pins before they reach an interrupt controller. Each pin passes through a two-stage synchroniser. The line's trigger mode then decides what counts as a request: a rising edge, a falling edge, either edge, a high level or a low level. Edge events are held in a sticky per-line latch until software acknowledges them. Level conditions pass straight through with no latch. Each line's request output is the detected condition gated by that line's mask bit.

Software sees two 32-bit configuration words through a one-cycle write port and a combinational read port. Word 0 serves lines 0 to 3 and word 1 serves lines 4 and 5. Inside a word, a line's bit in each field is its line number modulo 4. Each word holds, per line, a read-only status bit, a write-one-to-clear acknowledge bit, a mask bit and three mode bits. Everything resets to zero, so every line starts masked and in falling-edge mode.

Top module: `ext_irq_trigger_unit`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `irq_req` is all zero and both configuration words read back as zero.
- R2: A pin change is visible at the request output of a level-mode line after two rising clock edges. An edge on an edge-mode line sets its latch at the third rising edge.
- R3: Mode decode uses the line's level bit (bit 16+slot), polarity bit (bit 20+slot) and any-edge bit (bit 12+slot). With level=1, polarity=1 selects high level and polarity=0 selects low level. With level=0 and any-edge=1, both edges count. Otherwise polarity=1 selects the rising edge, and all three bits at 0 select the falling edge.
- R4: An edge-mode latch stays set after the pin returns to its idle level, until it is acknowledged.
- R5: Writing 1 to a line's acknowledge bit (bit 4+slot) clears its latch in the cycle of the write. Writing 0 there has no effect. The acknowledge bits always read back as 0.
- R6: If an acknowledge write and a new qualifying edge fall in the same cycle, the latch ends up set.
- R7: `irq_req[l]` is 1 exactly when line l's detected condition is 1 and its mask bit (bit 8+slot) is 1. Clearing the mask bit forces the request to 0.
- R8: `reg_sel`=0 addresses lines 0 to 3 and `reg_sel`=1 addresses lines 4 and up, with slot = line mod 4. Status bits (bits 0+slot) show the detected condition before masking. Bits belonging to absent lines, and bits 24 to 31, read as 0 and ignore writes. A write to one word leaves the other word's lines unchanged.
- R9: In level modes the request follows the synchronised pin with no latch, so it drops two edges after the pin leaves the active level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | NUM_LINES | Asynchronous external interrupt pins |
| reg_wr | input | 1 | Write strobe for the selected configuration word |
| reg_sel | input | 1 | Word select: 0 for lines 0-3, 1 for lines 4-5 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected word |
| irq_req | output | NUM_LINES | Per-line masked interrupt request |

## Verification
A corrupted latch shows on `irq_req` of a masked-in line in the very next cycle, and on the status bits of the selected word even while the line is masked. A wrong synchroniser depth or a wrong previous-sample register moves the request one cycle early or late, or produces a spurious edge. The bench's per-cycle comparison catches that at the first edge affected. Mode bits stored in the wrong slot or word show up as a different line responding, or as a readback mismatch immediately after the write.

// File: rtl/eitu_pkg.sv
package eitu_pkg;

  localparam int CFG_W     = 32;
  localparam int SLOTS     = 4;
  localparam int STAT_LSB  = 0;
  localparam int ACK_LSB   = 4;
  localparam int MASK_LSB  = 8;
  localparam int ANY_LSB   = 12;
  localparam int LVL_LSB   = 16;
  localparam int POL_LSB   = 20;

  typedef enum logic [2:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_ANY  = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_LOW  = 3'd4
  } trig_e;

  typedef struct packed {
    logic lvl;
    logic pol;
    logic any;
  } line_cfg_t;

  // word index that holds a given line
  function automatic int word_of(input int line);
    return line / SLOTS;
  endfunction

  // bit position of a line inside each field
  function automatic int slot_of(input int line);
    return line % SLOTS;
  endfunction

  function automatic trig_e decode_trig(input line_cfg_t c);
    if (c.lvl)      return c.pol ? TRIG_HIGH : TRIG_LOW;
    else if (c.any) return TRIG_ANY;
    else            return c.pol ? TRIG_RISE : TRIG_FALL;
  endfunction

  function automatic logic is_level(input trig_e m);
    return (m == TRIG_HIGH) || (m == TRIG_LOW);
  endfunction

  // edge qualification from current and previous synchronised samples
  function automatic logic edge_hit(input trig_e m, input logic cur, input logic prev);
    case (m)
      TRIG_RISE: return cur & ~prev;
      TRIG_FALL: return ~cur & prev;
      TRIG_ANY:  return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic level_hit(input trig_e m, input logic cur);
    case (m)
      TRIG_HIGH: return cur;
      TRIG_LOW:  return ~cur;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eitu_pin_sync.sv
module eitu_pin_sync #(
  parameter int NUM_LINES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_async,
  output logic [NUM_LINES-1:0] pin_sync,
  output logic [NUM_LINES-1:0] pin_prev
);

  logic [NUM_LINES-1:0] stage1_q;
  logic [NUM_LINES-1:0] stage2_q;
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pin_async;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign pin_sync = stage2_q;
  assign pin_prev = prev_q;

endmodule

// File: rtl/eitu_cfg_regs.sv
module eitu_cfg_regs
  import eitu_pkg::*;
#(
  parameter int NUM_LINES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_sel,
  input  logic [CFG_W-1:0]      reg_wdata,
  input  logic [NUM_LINES-1:0]  status,
  output logic [CFG_W-1:0]      reg_rdata,
  output logic [NUM_LINES-1:0]  mask_q,
  output line_cfg_t [NUM_LINES-1:0] cfg_q,
  output logic [NUM_LINES-1:0]  ack_pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      cfg_q  <= '0;
    end else if (reg_wr) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        if (word_of(l) == int'(reg_sel)) begin
          mask_q[l]    <= reg_wdata[MASK_LSB + slot_of(l)];
          cfg_q[l].lvl <= reg_wdata[LVL_LSB + slot_of(l)];
          cfg_q[l].pol <= reg_wdata[POL_LSB + slot_of(l)];
          cfg_q[l].any <= reg_wdata[ANY_LSB + slot_of(l)];
        end
      end
    end
  end

  always_comb begin
    ack_pulse = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (reg_wr && (word_of(l) == int'(reg_sel)))
        ack_pulse[l] = reg_wdata[ACK_LSB + slot_of(l)];
    end
  end

  // acknowledge field is never stored, so it reads as zero
  always_comb begin
    reg_rdata = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (word_of(l) == int'(reg_sel)) begin
        reg_rdata[STAT_LSB + slot_of(l)] = status[l];
        reg_rdata[MASK_LSB + slot_of(l)] = mask_q[l];
        reg_rdata[ANY_LSB  + slot_of(l)] = cfg_q[l].any;
        reg_rdata[LVL_LSB  + slot_of(l)] = cfg_q[l].lvl;
        reg_rdata[POL_LSB  + slot_of(l)] = cfg_q[l].pol;
      end
    end
  end

endmodule

// File: rtl/eitu_line.sv
module eitu_line
  import eitu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_cfg_t cfg,
  input  logic      lvl_now,
  input  logic      lvl_prev,
  input  logic      ack,
  output logic      edge_evt,
  output logic      latched,
  output logic      detected
);

  trig_e mode;
  logic  level_mode;

  assign mode       = decode_trig(cfg);
  assign level_mode = is_level(mode);
  assign edge_evt   = edge_hit(mode, lvl_now, lvl_prev);

  // a new edge takes precedence over an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)        latched <= 1'b0;
    else if (edge_evt) latched <= 1'b1;
    else if (ack)      latched <= 1'b0;
  end

  assign detected = level_mode ? level_hit(mode, lvl_now) : latched;

  assert_edge_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> latched);

  assert_ack_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !edge_evt) |=> !latched);

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !edge_evt) |=> $stable(latched));

endmodule

// File: rtl/ext_irq_trigger_unit.sv
module ext_irq_trigger_unit
  import eitu_pkg::*;
#(
  parameter int NUM_LINES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ext_pin,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_LINES-1:0] irq_req
);

  logic [NUM_LINES-1:0]      pin_sync;
  logic [NUM_LINES-1:0]      pin_prev;
  logic [NUM_LINES-1:0]      mask_q;
  logic [NUM_LINES-1:0]      ack_pulse;
  logic [NUM_LINES-1:0]      detected;
  logic [NUM_LINES-1:0]      edge_evt;
  logic [NUM_LINES-1:0]      latched;
  line_cfg_t [NUM_LINES-1:0] cfg_q;

  eitu_pin_sync #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (ext_pin),
    .pin_sync  (pin_sync),
    .pin_prev  (pin_prev)
  );

  eitu_cfg_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .status    (detected),
    .reg_rdata (reg_rdata),
    .mask_q    (mask_q),
    .cfg_q     (cfg_q),
    .ack_pulse (ack_pulse)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    eitu_line u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg_q[l]),
      .lvl_now  (pin_sync[l]),
      .lvl_prev (pin_prev[l]),
      .ack      (ack_pulse[l]),
      .edge_evt (edge_evt[l]),
      .latched  (latched[l]),
      .detected (detected[l])
    );

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_q[l] |-> !irq_req[l]);
  end

  assign irq_req = detected & mask_q;

endmodule

// File: tb/ext_irq_trigger_unit_tb_top.sv
module ext_irq_trigger_unit_tb_top;

  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic         wr = 1'b0;
  logic         sel = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [N-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_irq_trigger_unit #(.NUM_LINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin(pins), .reg_wr(wr), .reg_sel(sel),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_req(irq)
  );

  // behavioural reference: per-line integer state
  int s1[N], s2[N], pv[N], lat[N], msk[N], lvl[N], pol[N], any[N];

  function automatic int m_det(int l);
    if (lvl[l] != 0) return (s2[l] == pol[l]) ? 1 : 0;
    return lat[l];
  endfunction

  function automatic logic [31:0] m_word(int w);
    logic [31:0] r = '0;
    for (int l = 0; l < N; l++) begin
      if (l / 4 == w) begin
        r[l % 4]      = m_det(l) != 0;
        r[8 + l % 4]  = msk[l] != 0;
        r[12 + l % 4] = any[l] != 0;
        r[16 + l % 4] = lvl[l] != 0;
        r[20 + l % 4] = pol[l] != 0;
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    for (int l = 0; l < N; l++) begin
      int ev;
      ev = 0;
      if (!rst_n) begin
        s1[l] = 0; s2[l] = 0; pv[l] = 0; lat[l] = 0;
        msk[l] = 0; lvl[l] = 0; pol[l] = 0; any[l] = 0;
      end else begin
        if (lvl[l] == 0) begin
          if (any[l] != 0)      ev = (s2[l] != pv[l]) ? 1 : 0;
          else if (pol[l] != 0) ev = (s2[l] == 1 && pv[l] == 0) ? 1 : 0;
          else                  ev = (s2[l] == 0 && pv[l] == 1) ? 1 : 0;
        end
        if (ev != 0) lat[l] = 1;
        else if (wr && int'(sel) == l / 4 && wdata[4 + l % 4]) lat[l] = 0;
        pv[l] = s2[l]; s2[l] = s1[l]; s1[l] = int'(pins[l]);
        if (wr && int'(sel) == l / 4) begin
          msk[l] = int'(wdata[8 + l % 4]);
          any[l] = int'(wdata[12 + l % 4]);
          lvl[l] = int'(wdata[16 + l % 4]);
          pol[l] = int'(wdata[20 + l % 4]);
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare against the model every cycle, a quarter period after the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      logic [N-1:0] e;
      for (int l = 0; l < N; l++) e[l] = (m_det(l) != 0) && (msk[l] != 0);
      chk("R7 per-cycle irq_req", 32'(irq), 32'(e));
      chk("R8 per-cycle readback", rdata, m_word(int'(sel)));
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_word(logic s, logic [31:0] d);
    wr = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'h0);
    sel = 1'b0; #1;
    chk("R1 word0 after reset", rdata, 32'h0);
    sel = 1'b1; #1;
    chk("R1 word1 after reset", rdata, 32'h0);
    sel = 1'b0;

    // R2/R9 level high on line 0
    wr_word(1'b0, 32'h0011_0100);
    pins[0] = 1'b1;
    tick(1); chk("R2 level not yet", 32'(irq[0]), 32'h0);
    tick(1); chk("R2 level after two edges", 32'(irq[0]), 32'h1);
    pins[0] = 1'b0;
    tick(2); chk("R9 level drops without latch", 32'(irq[0]), 32'h0);

    // R2/R4/R5 rising edge on line 1
    wr_word(1'b0, 32'h0020_0200);
    pins[1] = 1'b1;
    tick(2); chk("R2 edge not yet latched", 32'(irq[1]), 32'h0);
    tick(1); chk("R2 edge latched at third edge", 32'(irq[1]), 32'h1);
    pins[1] = 1'b0;
    tick(5); chk("R4 latch sticky", 32'(irq[1]), 32'h1);
    wr_word(1'b0, 32'h0020_0200);
    chk("R5 ack bit zero has no effect", 32'(irq[1]), 32'h1);
    wr_word(1'b0, 32'h0020_0220);
    chk("R5 ack clears latch", 32'(irq[1]), 32'h0);
    chk("R5 ack field reads zero", rdata & 32'h0000_00F0, 32'h0);

    // R3 falling default on line 2
    wr_word(1'b0, 32'h0000_0400);
    pins[2] = 1'b1;
    tick(4); chk("R3 falling ignores rise", 32'(irq[2]), 32'h0);
    pins[2] = 1'b0;
    tick(3); chk("R3 falling edge latched", 32'(irq[2]), 32'h1);
    wr_word(1'b0, 32'h0000_0440);

    // R3 any edge on line 3
    wr_word(1'b0, 32'h0000_8800);
    pins[3] = 1'b1;
    tick(3); chk("R3 any edge rise", 32'(irq[3]), 32'h1);
    wr_word(1'b0, 32'h0000_8880);
    chk("R3 any edge cleared", 32'(irq[3]), 32'h0);
    pins[3] = 1'b0;
    tick(3); chk("R3 any edge fall", 32'(irq[3]), 32'h1);

    // R6 edge and ack in the same cycle on line 1
    wr_word(1'b0, 32'h0020_0200);
    tick(2);
    pins[1] = 1'b1;
    tick(2);
    wr_word(1'b0, 32'h0020_0220);
    chk("R6 edge wins over ack", 32'(irq[1]), 32'h1);

    // R7 mask gating with low level on line 3
    wr_word(1'b0, 32'h0008_0000);
    tick(2);
    chk("R7 masked line quiet", 32'(irq[3]), 32'h0);
    chk("R8 status shows unmasked condition", 32'(rdata[3]), 32'h1);
    wr_word(1'b0, 32'h0008_0800);
    chk("R7 unmasked line requests", 32'(irq[3]), 32'h1);

    // R8 second word serves lines 4 and 5
    wr_word(1'b1, 32'h0033_0300);
    pins[5:4] = 2'b11;
    tick(2);
    chk("R8 word1 lines request", 32'(irq[5:4]), 32'h3);
    chk("R8 word1 readback", rdata, 32'h0033_0303);
    wr_word(1'b1, 32'hFFFF_FFFF);
    chk("R8 absent bits read zero", rdata, 32'h0033_3303);
    chk("R8 word0 untouched", 32'(irq[3]), 32'h1);

    tick(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule